// File: doc/BRIEF.md
# Start-Up Event Sequencer

This block runs the short start-up sequence that follows the loading of a programmable device. A start trigger begins an eight-phase count, phases 0 to 7, on the start-up clock. Four events are placed on that count: release of the shared DONE line, release of the global output tristate, release of the global set/reset, and enabling of global writes. Each event is placed by a 3-bit setting. Once an event has fired it stays fired until reset. A sequence-complete flag rises when the count leaves phase 7.

The three global events can instead be tied to the DONE line. The line is wired across several devices, and each device can only pull it low or let it go. A tied event fires one clock after the sensed line is first seen high. In that case the counter waits at the phase just after this device lets go of DONE. As a result, every device on the line finishes start-up only after all of them have released DONE. Settings are captured when the sequence starts. An illegal setting falls back to phase 6 and raises an error flag.

Top module: `startup_sequencer`

## Requirements
- R1: After reset and until the start trigger is sampled high, DONE is driven low (`doneRelease`=0), and `gtsRelease`, `gsrRelease`, `gweEnable`, `seqDone` and `cfgError` are all 0.
- R2: If the start trigger is sampled at clock edge E0, an event whose 3-bit setting p lies in 1..6 goes high in the cycle after edge E0+p.
- R3: Events that carry the same setting rise in the same cycle, and so do several events whose firing points coincide.
- R4: Every event output and `seqDone` stay high until reset. A start trigger after the sequence has begun has no effect.
- R5: If the counter never waits, `seqDone` rises after edge E0+8. When it rises, all four event outputs are already high.
- R6: The code 7 on the GTS, GSR or GWE setting ties that event to DONE. Let X be the first edge at which `doneSense` is sampled high while `doneRelease` is 1. The tied event then rises after edge X+1.
- R7: If any global setting is 7, the counter waits at phase d+1 (d being the DONE phase) until edge X+1. Untied events placed above d+1 are delayed by the stall X-d-1 cycles, and so is `seqDone`.
- R8: A high `doneSense` while this block still drives DONE low is ignored. With no setting at 7, `doneSense` has no effect on any timing.
- R9: A DONE setting of 0 or 7, or a global setting of 0, is illegal. It is treated as phase 6, and `cfgError` goes high after edge E0 and stays constant until reset.
- R10: Settings are captured at E0. Later changes to the setting inputs have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start trigger, sampled in idle |
| doneSense | input | 1 | Sensed level of the shared DONE line |
| cfgDonePhase | input | 3 | DONE release phase (1..6) |
| cfgGtsPhase | input | 3 | Tristate release phase (1..6, 7 = tied to DONE) |
| cfgGsrPhase | input | 3 | Set/reset release phase (1..6, 7 = tied to DONE) |
| cfgGwePhase | input | 3 | Write-enable phase (1..6, 7 = tied to DONE) |
| doneRelease | output | 1 | 1 = DONE released, 0 = DONE pulled low |
| gtsRelease | output | 1 | Global tristate released |
| gsrRelease | output | 1 | Global set/reset released |
| gweEnable | output | 1 | Global write enable |
| seqDone | output | 1 | Sequence complete |
| cfgError | output | 1 | An illegal setting was captured at start |

## Verification
The sequence is run with several kinds of settings:
- Distinct phases, which confirm that each event keeps its own offset.
- Coinciding phases, which confirm that events fire together.
- Tied events with the shared line already high, which must add no stall.
- Tied events with the line released late, which must produce a stall of exactly X-d-1 cycles, including when DONE sits at phase 6.
- Illegal codes, which must land on phase 6 and raise the error flag.

Further directed runs check a few things the vectors do not:
- A line pulse that arrives before this block releases DONE must not end the wait.
- Setting changes made after start must not move any event.
- A second start trigger after the sequence has begun must change nothing.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  localparam int PHASE_W    = 3;
  localparam int NUM_PHASES = 1 << PHASE_W;
  localparam int LAST_PHASE = NUM_PHASES - 1;
  localparam int EVT_MIN    = 1;
  localparam int EVT_MAX    = NUM_PHASES - 2;
  localparam int SYNC_CODE  = NUM_PHASES - 1;
  localparam int NUM_EVT    = 4;
  localparam int EVT_DONE   = 0;
  localparam int EVT_GTS    = 1;
  localparam int EVT_GSR    = 2;
  localparam int EVT_GWE    = 3;

  typedef logic [PHASE_W-1:0] phaseT;

  typedef struct packed {
    logic load;   // capture settings, restart counter
    logic step;   // advance phase counter
  } seqStrobeT;

  typedef struct packed {
    logic atLast;   // counter shows the final phase
    logic holdReq;  // waiting for the shared DONE line
  } seqStatusT;
endpackage

// File: rtl/startup_event_slot.sv
module startup_event_slot
  import startup_seq_pkg::*;
#(
  parameter bit ALLOW_SYNC = 1'b1
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  load,
  input  phaseT cfgIn,
  input  logic  step,
  input  phaseT phaseCur,
  input  logic  doneSeen,
  output logic  fired,
  output logic  isSync,
  output logic  cfgBad,
  output logic  atHold
);
  logic  legalPhase;
  logic  syncReq;
  phaseT decoded;
  phaseT phaseQ;
  logic  syncQ;
  phaseT phaseNext;

  always_comb begin
    legalPhase = (int'(cfgIn) >= EVT_MIN) && (int'(cfgIn) <= EVT_MAX);
    syncReq    = ALLOW_SYNC && (int'(cfgIn) == SYNC_CODE);
    cfgBad     = !legalPhase && !syncReq;
    decoded    = legalPhase ? cfgIn : phaseT'(EVT_MAX);
    phaseNext  = phaseCur + phaseT'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= phaseT'(EVT_MAX);
      syncQ  <= 1'b0;
      fired  <= 1'b0;
    end else if (load) begin
      phaseQ <= decoded;
      syncQ  <= syncReq;
      fired  <= 1'b0;
    end else if (!fired) begin
      if (syncQ) begin
        if (doneSeen) fired <= 1'b1;
      end else if (step && (phaseNext == phaseQ)) begin
        fired <= 1'b1;
      end
    end
  end

  assign isSync = syncQ;
  assign atHold = (phaseCur == (phaseQ + phaseT'(1)));
endmodule

// File: rtl/startup_seq_datapath.sv
module startup_seq_datapath
  import startup_seq_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  seqStrobeT                       strobe,
  input  logic [NUM_EVT-1:0][PHASE_W-1:0] cfgVec,
  input  logic                            doneSense,
  output seqStatusT                       status,
  output logic [NUM_EVT-1:0]              evtFired,
  output logic                            cfgError
);
  localparam logic [NUM_EVT-1:0] DONE_MASK = NUM_EVT'(1) << EVT_DONE;

  phaseT              phaseQ;
  logic               doneSeen;
  logic [NUM_EVT-1:0] syncVec;
  logic [NUM_EVT-1:0] badVec;
  logic [NUM_EVT-1:0] holdVec;
  logic               syncAny;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_slot
    startup_event_slot #(.ALLOW_SYNC(i != EVT_DONE)) slot_i (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.load),
      .cfgIn    (cfgVec[i]),
      .step     (strobe.step),
      .phaseCur (phaseQ),
      .doneSeen (doneSeen),
      .fired    (evtFired[i]),
      .isSync   (syncVec[i]),
      .cfgBad   (badVec[i]),
      .atHold   (holdVec[i])
    );
  end

  assign syncAny = |syncVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= '0;
      doneSeen <= 1'b0;
      cfgError <= 1'b0;
    end else if (strobe.load) begin
      phaseQ   <= '0;
      doneSeen <= 1'b0;
      cfgError <= |badVec;
    end else begin
      if (strobe.step) phaseQ <= phaseQ + phaseT'(1);
      if (evtFired[EVT_DONE] && doneSense) doneSeen <= 1'b1;
    end
  end

  always_comb begin
    status.atLast  = (phaseQ == phaseT'(LAST_PHASE));
    status.holdReq = syncAny && (|(holdVec & DONE_MASK)) && !doneSeen;
  end
endmodule

// File: rtl/startup_seq_ctrl.sv
module startup_seq_ctrl
  import startup_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  seqStatusT status,
  output seqStrobeT strobe,
  output logic      seqDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seqStateT;

  seqStateT state;
  logic     finishNow;

  always_comb begin
    strobe    = '0;
    finishNow = 1'b0;
    unique case (state)
      ST_IDLE: strobe.load = startReq;
      ST_RUN: begin
        if (!status.holdReq) begin
          if (status.atLast) finishNow   = 1'b1;
          else               strobe.step = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      if (strobe.load)    state <= ST_RUN;
      else if (finishNow) state <= ST_FIN;
    end
  end

  assign seqDone = (state == ST_FIN);
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               doneSense,
  input  logic [PHASE_W-1:0] cfgDonePhase,
  input  logic [PHASE_W-1:0] cfgGtsPhase,
  input  logic [PHASE_W-1:0] cfgGsrPhase,
  input  logic [PHASE_W-1:0] cfgGwePhase,
  output logic               doneRelease,
  output logic               gtsRelease,
  output logic               gsrRelease,
  output logic               gweEnable,
  output logic               seqDone,
  output logic               cfgError
);
  seqStrobeT                       strobe;
  seqStatusT                       status;
  logic [NUM_EVT-1:0][PHASE_W-1:0] cfgVec;
  logic [NUM_EVT-1:0]              evtFired;

  always_comb begin
    cfgVec[EVT_DONE] = cfgDonePhase;
    cfgVec[EVT_GTS]  = cfgGtsPhase;
    cfgVec[EVT_GSR]  = cfgGsrPhase;
    cfgVec[EVT_GWE]  = cfgGwePhase;
  end

  startup_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .status   (status),
    .strobe   (strobe),
    .seqDone  (seqDone)
  );

  startup_seq_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgVec    (cfgVec),
    .doneSense (doneSense),
    .status    (status),
    .evtFired  (evtFired),
    .cfgError  (cfgError)
  );

  assign doneRelease = evtFired[EVT_DONE];
  assign gtsRelease  = evtFired[EVT_GTS];
  assign gsrRelease  = evtFired[EVT_GSR];
  assign gweEnable   = evtFired[EVT_GWE];
endmodule

// File: rtl/startup_seq_checker.sv
module startup_seq_checker
  import startup_seq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic               doneSense,
  input logic [PHASE_W-1:0] cfgGtsPhase,
  input logic [PHASE_W-1:0] cfgGsrPhase,
  input logic [PHASE_W-1:0] cfgGwePhase,
  input logic               doneRelease,
  input logic               gtsRelease,
  input logic               gsrRelease,
  input logic               gweEnable,
  input logic               seqDone,
  input logic               cfgError
);
  logic started;
  logic seen;
  logic gtsTied;
  logic gsrTied;
  logic gweTied;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      seen    <= 1'b0;
      gtsTied <= 1'b0;
      gsrTied <= 1'b0;
      gweTied <= 1'b0;
    end else begin
      if (!started && startReq) begin
        started <= 1'b1;
        gtsTied <= (int'(cfgGtsPhase) == SYNC_CODE);
        gsrTied <= (int'(cfgGsrPhase) == SYNC_CODE);
        gweTied <= (int'(cfgGwePhase) == SYNC_CODE);
      end
      if (doneRelease && doneSense) seen <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> !(doneRelease || gtsRelease || gsrRelease || gweEnable || seqDone || cfgError)); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneRelease |=> doneRelease); // R4
  AST_GTS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    gtsRelease |=> gtsRelease); // R4
  AST_GSR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    gsrRelease |=> gsrRelease); // R4
  AST_GWE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    gweEnable |=> gweEnable); // R4
  AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> seqDone); // R4
  AST_SEQ_ALL_FIRED: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (doneRelease && gtsRelease && gsrRelease && gweEnable)); // R5
  AST_GTS_TIED_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (gtsTied && $rose(gtsRelease)) |-> $past(seen)); // R6
  AST_GSR_TIED_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (gsrTied && seen) |=> gsrRelease); // R6
  AST_GWE_TIED_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (gweTied && seen) |=> gweEnable); // R6
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started)) |-> $stable(cfgError)); // R9
endmodule

bind startup_sequencer startup_seq_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .doneSense   (doneSense),
  .cfgGtsPhase (cfgGtsPhase),
  .cfgGsrPhase (cfgGsrPhase),
  .cfgGwePhase (cfgGwePhase),
  .doneRelease (doneRelease),
  .gtsRelease  (gtsRelease),
  .gsrRelease  (gsrRelease),
  .gweEnable   (gweEnable),
  .seqDone     (seqDone),
  .cfgError    (cfgError)
);

// File: tb/startup_sequencer_tb.sv
`timescale 1ns/1ps
module startup_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       extLine = 1'b0;
  logic       pokeSense = 1'b0;
  logic [2:0] cfgDone = 3'd1, cfgGts = 3'd1, cfgGsr = 3'd1, cfgGwe = 3'd1;
  logic       doneRelease, gtsRelease, gsrRelease, gweEnable, seqDone, cfgError;
  logic       doneSense;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  // Wired line: high only when this device and the other devices release it.
  assign doneSense = pokeSense | (doneRelease & extLine);

  startup_sequencer dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .doneSense    (doneSense),
    .cfgDonePhase (cfgDone),
    .cfgGtsPhase  (cfgGts),
    .cfgGsrPhase  (cfgGsr),
    .cfgGwePhase  (cfgGwe),
    .doneRelease  (doneRelease),
    .gtsRelease   (gtsRelease),
    .gsrRelease   (gsrRelease),
    .gweEnable    (gweEnable),
    .seqDone      (seqDone),
    .cfgError     (cfgError)
  );

  // Fields: done, gts, gsr, gwe settings, external release edge r,
  // then expected rise cycles (done, gts, gsr, gwe, seqDone) and cfgError.
  localparam int NVEC = 9;
  localparam int VEC [NVEC][11] = '{
    '{3, 4, 5, 6,  0,   3,  4,  5,  6,  8, 0},  // R2 distinct phases
    '{1, 2, 2, 6,  0,   1,  2,  2,  6,  8, 0},  // R3 shared phase
    '{2, 7, 7, 7,  0,   2,  4,  4,  4,  8, 0},  // R6 tied, line already high
    '{2, 7, 7, 5, 10,   2, 12, 12, 13, 16, 0},  // R7 stall delays later event
    '{6, 7, 3, 7,  9,   6, 11,  3, 11, 11, 0},  // R7 wait at last phase
    '{7, 0, 1, 2,  0,   6,  6,  1,  2,  8, 1},  // R9 illegal codes
    '{5, 3, 4, 1, 20,   5,  3,  4,  1,  8, 0},  // R8 line ignored when untied
    '{4, 7, 7, 7, 20,   4, 22, 22, 22, 24, 0},  // R7 long stall
    '{0, 7, 0, 6,  3,   6,  8,  6,  6,  8, 1}   // R9 with tied event
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    startReq = 1'b0;
    extLine = 1'b0;
    pokeSense = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runSeq(input int d, input int g, input int s, input int w,
                        input int r, input bit poke, input bit swap,
                        output int fr[6]);
    doReset();
    cfgDone = 3'(d); cfgGts = 3'(g); cfgGsr = 3'(s); cfgGwe = 3'(w);
    @(negedge clk);
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < 6; i++) fr[i] = -1;
    if (swap) begin
      cfgDone = 3'd1; cfgGts = 3'd1; cfgGsr = 3'd1; cfgGwe = 3'd1;
    end
    if (doneRelease) fr[0] = 0;
    if (gtsRelease)  fr[1] = 0;
    if (gsrRelease)  fr[2] = 0;
    if (gweEnable)   fr[3] = 0;
    if (seqDone)     fr[4] = 0;
    extLine = (r <= 0);
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (doneRelease && fr[0] < 0) fr[0] = k;
      if (gtsRelease  && fr[1] < 0) fr[1] = k;
      if (gsrRelease  && fr[2] < 0) fr[2] = k;
      if (gweEnable   && fr[3] < 0) fr[3] = k;
      if (seqDone     && fr[4] < 0) fr[4] = k;
      if (k == 1) fr[5] = int'(cfgError);
      extLine   = (k >= r);
      pokeSense = poke && (k == 1 || k == 2);
    end
    pokeSense = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        finishRun();
      end
    end
  end

  initial begin
    int fr[6];
    string tag;

    // R1: reset and idle state
    doReset();
    extLine = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 idle outputs", int'({doneRelease, gtsRelease, gsrRelease, gweEnable, seqDone, cfgError}), 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      runSeq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0, 1'b0, fr);
      tag = $sformatf("vec%0d R2/R3/R6/R7 done rise", v);  check(tag, fr[0], VEC[v][5]);
      tag = $sformatf("vec%0d R2/R6/R7 gts rise", v);      check(tag, fr[1], VEC[v][6]);
      tag = $sformatf("vec%0d R2/R6/R7 gsr rise", v);      check(tag, fr[2], VEC[v][7]);
      tag = $sformatf("vec%0d R2/R6/R7 gwe rise", v);      check(tag, fr[3], VEC[v][8]);
      tag = $sformatf("vec%0d R5/R7 seqDone rise", v);     check(tag, fr[4], VEC[v][9]);
      tag = $sformatf("vec%0d R9 cfgError", v);            check(tag, fr[5], VEC[v][10]);
    end

    // R8: sense pulse while DONE still pulled low must not end the wait
    runSeq(4, 7, 7, 7, 12, 1'b1, 1'b0, fr);
    check("R8 tied gts after early pulse", fr[1], 14);
    check("R8 seqDone after early pulse", fr[4], 16);

    // R10: settings changed after start are ignored
    runSeq(5, 5, 5, 5, 0, 1'b0, 1'b1, fr);
    check("R10 done keeps captured phase", fr[0], 5);
    check("R10 gwe keeps captured phase", fr[3], 5);

    // R4: a second trigger after completion changes nothing; outputs hold
    runSeq(3, 4, 5, 6, 0, 1'b0, 1'b0, fr);
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 outputs held after retrigger",
          int'({doneRelease, gtsRelease, gsrRelease, gweEnable, seqDone}), 31);

    // R1/R4: reset clears everything
    doReset();
    @(negedge clk);
    check("R1 outputs cleared by reset",
          int'({doneRelease, gtsRelease, gsrRelease, gweEnable, seqDone, cfgError}), 0);

    finishRun();
  end
endmodule